// File: doc/BRIEF.md
# Octave-Scaled Square Tone Generator

This block is one voice of a small synthesizer. From a 3-bit octave code and a 4-bit semitone code it makes a one-bit square wave. No multiplier is involved. A free-running prescaler makes a base tick every `BASE_DIV` clocks. An octave divider then thins that tick into a clock-enable. The enable runs at the full base rate for the highest octave code, and its rate halves for each code below. On every enable a half-period counter advances. When the counter reaches the length given by a twelve-entry semitone table, it wraps and the output flips.

One table serves every octave, because the octave only changes the enable rate. With the default `BASE_DIV` of 64 at a 50 MHz system clock, the base tick runs at 781.25 kHz. The table then gives equal-tempered pitches, with octave code 7 landing on C7 through B7. Semitone codes 12 to 15 mean silence. A change of either code makes the counter restart cleanly at the next enable.

Top module: `octave_tone_gen`

## Requirements
- R1: While `rst_n` is low and on the first clock after its release, `tone` is 0.
- R2: The half-period table, in enable ticks, indexed by semitone code 0..11 is 187, 176, 166, 157, 148, 140, 132, 125, 118, 111, 105, 99.
- R3: The enable period in clocks is `BASE_DIV * 2^(7 - octave)`. Code 7 uses the undivided base tick.
- R4: With stable inputs and a valid semitone code, each high phase and each low phase of `tone` lasts exactly table[pitch] * `BASE_DIV` * 2^(7 - octave) clocks.
- R5: A semitone code of 12 to 15 forces `tone` to 0 on the next clock and holds it there. The counter is cleared while the code stays invalid.
- R6: After any change of `octave` or `pitch`, the counter restarts from zero at the next enable. The first edge therefore comes no later than (table[pitch] + 1) enable periods after the change.
- R7: `tone` changes only on a clock that follows an enable, or on a clock that follows an invalid semitone code.
- R8: With a valid code and stable inputs, the counter stays below the table length after every enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| octave | input | 3 | Octave code, 7 is highest |
| pitch | input | 4 | Semitone code 0..11, 12..15 silent |
| tone | output | 1 | Square wave output |

## Verification
`tone` is a register, so a change to `pitch` or `octave` shows at the output in the clock after it is sampled. Silencing is visible one clock after an invalid code. A new note's first edge only comes after the restart enable plus a full table length of enables. For that reason the bench never measures the edges just after a change. It skips two edges and then times whole half-periods between consecutive edges, in clock counts that it takes at the falling edge. It compares those counts against the table times the enable period. The restart bound and the silence hold are checked as windows measured from the cycle in which the input was driven.

// File: rtl/octave_tone_gen.sv
module octave_tone_gen #(
  parameter int BASE_DIV = 64,
  parameter int OCT_W    = 3,
  parameter int PITCH_W  = 4,
  parameter int CNT_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OCT_W-1:0]   octave,
  input  logic [PITCH_W-1:0] pitch,
  output logic               tone
);
  localparam int TOP_OCT = (1 << OCT_W) - 1;
  localparam int DIV_W   = TOP_OCT;
  localparam int PRE_W   = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int NOTES   = 12;

  function automatic logic [CNT_W-1:0] half_len_of(input logic [PITCH_W-1:0] p);
    case (p)
      4'd0:    half_len_of = CNT_W'(187);
      4'd1:    half_len_of = CNT_W'(176);
      4'd2:    half_len_of = CNT_W'(166);
      4'd3:    half_len_of = CNT_W'(157);
      4'd4:    half_len_of = CNT_W'(148);
      4'd5:    half_len_of = CNT_W'(140);
      4'd6:    half_len_of = CNT_W'(132);
      4'd7:    half_len_of = CNT_W'(125);
      4'd8:    half_len_of = CNT_W'(118);
      4'd9:    half_len_of = CNT_W'(111);
      4'd10:   half_len_of = CNT_W'(105);
      4'd11:   half_len_of = CNT_W'(99);
      default: half_len_of = CNT_W'(1);
    endcase
  endfunction

  logic             base_tick;
  logic [DIV_W-1:0] oct_div;
  logic [DIV_W:0]   oct_mask;
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_len;
  logic [OCT_W-1:0] last_oct;
  logic [PITCH_W-1:0] last_pitch;
  logic             restart;
  logic             changed;
  logic             valid;

  generate
    if (BASE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (!rst_n || pre == PRE_W'(BASE_DIV - 1)) pre <= '0;
        else pre <= pre + 1'b1;
      end
      assign base_tick = rst_n && (pre == PRE_W'(BASE_DIV - 1));
    end else begin : g_nopre
      assign base_tick = rst_n;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) oct_div <= '0;
    else if (base_tick) oct_div <= oct_div + 1'b1;
  end

  assign oct_mask = ((DIV_W+1)'(1) << (TOP_OCT - int'(octave))) - 1'b1;
  assign en       = base_tick && ((oct_div & oct_mask[DIV_W-1:0]) == '0);
  assign valid    = int'(pitch) < NOTES;
  assign half_len = half_len_of(pitch);
  assign changed  = (octave != last_oct) || (pitch != last_pitch);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      tone       <= 1'b0;
      restart    <= 1'b0;
      last_oct   <= '0;
      last_pitch <= '0;
    end else begin
      last_oct   <= octave;
      last_pitch <= pitch;
      if (changed) restart <= 1'b1;
      if (!valid) begin
        cnt     <= '0;
        tone    <= 1'b0;
        restart <= 1'b0;
      end else if (en) begin
        if (restart || changed) begin
          cnt     <= '0;
          restart <= 1'b0;
        end else if (cnt >= half_len - 1'b1) begin
          cnt  <= '0;
          tone <= ~tone;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_SILENT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !tone); // R5
  AST_EDGE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && valid) |=> $stable(tone)); // R7
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid) |=> (!$stable(pitch) || cnt < half_len)); // R8
  AST_ENABLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (BASE_DIV > 1 || int'(octave) != TOP_OCT)) |=> (!$stable(octave) || !en)); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !tone); // R1
endmodule

// File: tb/octave_tone_gen_tb.sv
module octave_tone_gen_tb_top;
  localparam int BD = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] octave = 3'd7;
  logic [3:0] pitch = 4'd0;
  logic tone;
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  octave_tone_gen #(.BASE_DIV(BD)) dut_i (
    .clk(clk), .rst_n(rst_n), .octave(octave), .pitch(pitch), .tone(tone));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int note_len(input int p);
    int t[12] = '{187, 176, 166, 157, 148, 140, 132, 125, 118, 111, 105, 99};
    return t[p];
  endfunction

  function automatic int exp_half(input int o, input int p);
    return note_len(p) * BD * (1 << (7 - o));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(input int limit, output int when);
    logic prev;
    @(negedge clk);
    prev = tone;
    when = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (tone != prev) begin
        when = cyc;
        break;
      end
    end
  endtask

  task automatic measure(input int o, input int p, input string req);
    int t0, t1, t2, e, lim;
    octave = 3'(o);
    pitch  = 4'(p);
    e   = exp_half(o, p);
    lim = 3 * e + 1000;
    wait_edge(lim, t0);
    wait_edge(lim, t0);
    wait_edge(lim, t0);
    wait_edge(lim, t1);
    wait_edge(lim, t2);
    if (t0 < 0 || t1 < 0 || t2 < 0) begin
      check(req, -1, e);
    end else begin
      check(req, t1 - t0, e);
      check(req, t2 - t1, e);
    end
  endtask

  initial begin
    int seen, t_start, t_first, o, p;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R1 in reset", int'(tone), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(tone), 0);

    for (int k = 0; k < 12; k++) measure(7, k, "R2 table at top octave");
    measure(6, 0, "R3 octave 6");
    measure(2, 11, "R4 low octave");
    for (int k = 0; k < 6; k++) begin
      o = 4 + int'($urandom % 4);
      p = int'($urandom % 12);
      measure(o, p, "R4 random note");
    end

    pitch = 4'd13;
    @(negedge clk);
    @(negedge clk);
    check("R5 silent after invalid", int'(tone), 0);
    seen = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (tone) seen++;
    end
    check("R5 silence holds", seen, 0);
    pitch = 4'd15;
    repeat (300) @(negedge clk);
    check("R5 code 15 silent", int'(tone), 0);

    measure(7, 0, "R6 settle long note");
    octave  = 3'd6;
    pitch   = 4'd11;
    t_start = cyc;
    wait_edge(4000, t_first);
    seen = (t_first >= 0 && (t_first - t_start) <= (99 + 1) * BD * 2 + 3) ? 1 : 0;
    check("R6 restart bound", seen, 1);
    measure(6, 11, "R6 period after change");
    measure(5, 4, "R7 octave step");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule